// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the control unit of a 32-bit processor that completes one instruction per clock. It reads the 6-bit opcode and 6-bit function fields of the current instruction, the reset and interrupt request lines, and the four flags from the ALU. It then produces, in the same cycle, every select and strobe the datapath needs. These cover the register-file write and its address and data sources, the two ALU operand sources, the immediate extension mode, the ALU operation, the data-memory write and the next-PC source.

The block contains no state. Branch and set-less-than outcomes are resolved here from the ALU flags: the datapath computes the subtraction, and the decoder picks the next PC or the value to write back. An opcode or function code outside the supported set becomes a trap that saves the return address in register 27. An interrupt request overrides whatever instruction is present and takes the same register-27 path to a separate vector. Reset overrides everything else.

Top module: `ctl_decoder`

## Requirements
- R1: While rst_i is 1, pc_sel_o is 4 (reset vector), rf_we_o and mem_we_o are 0 and every other output holds its idle value, regardless of irq_i, opcode, function code or flags.
- R2: Idle values, held by every field an instruction does not use: a_sel_o=0 (rs), b_sel_o=0 (rt), sext_o=1 (sign-extend; 0 means zero-extend), wa_sel_o=0 (rd), wd_sel_o=0 (ALU result), alu_fn_o=5'b00000 (add), pc_sel_o=0 (PC+4), less_o=0, rf_we_o=0, mem_we_o=0.
- R3: Opcode 000000 with function 100000/100001 gives add, 100010/100011 subtract (5'b00001), 100100 AND (5'b01000), 100101 OR (5'b01001), 100110 XOR (5'b01010) and 100111 NOR (5'b01011). Each sets rf_we_o=1 and wa_sel_o=0 (rd).
- R4: Opcode 000000 with function 000000/000010/000011 is a shift by constant, with a_sel_o=1 (shamt field). Function 000100/000110/000111 is the matching shift by register, with a_sel_o=0. The codes are 5'b10000 for left, 5'b10001 for logical right and 5'b10011 for arithmetic right, and each writes rd.
- R5: Opcodes 001000/001001 add an immediate with sext_o=1. Opcodes 001100/001101/001110 perform AND/OR/XOR with sext_o=0. All of them set b_sel_o=1 (immediate), wa_sel_o=1 (rt) and rf_we_o=1.
- R6: Opcode 001111 (load upper) sets a_sel_o=2 (constant 16), b_sel_o=1, sext_o=0, alu_fn_o=shift left and writes rt.
- R7: Set-less-than forms select subtract and wd_sel_o=3 (less bit). These are function 101010 (signed) and 101011 (unsigned) under opcode 000000, and opcodes 001010 (signed) and 001011 (unsigned) with sext_o=1, b_sel_o=1 and rt. less_o is neg_i XOR ovf_i for signed forms and NOT carry_i for unsigned forms, where carry_i is the carry out of A + ~B + 1.
- R8: Opcode 100011 (load) sets rf_we_o=1, wa_sel_o=1, wd_sel_o=1 (memory data), b_sel_o=1 and sext_o=1 with add. Opcode 101011 (store) sets mem_we_o=1, b_sel_o=1 and sext_o=1 with add, and rf_we_o=0.
- R9: Opcodes 000100 (branch if equal) and 000101 (branch if not equal) select subtract with no register write. pc_sel_o is 1 (branch target) when zero_i is 1 for the first, or 0 for the second; otherwise pc_sel_o is 0.
- R10: Opcode 000010 sets pc_sel_o=2 (jump target). Opcode 000011 does the same and also sets rf_we_o=1, wa_sel_o=2 (register 31) and wd_sel_o=2 (PC+4).
- R11: Opcode 000000 with function 001000 sets pc_sel_o=3 (register target) with no write. Function 001001 sets pc_sel_o=3 with rf_we_o=1, wa_sel_o=0 and wd_sel_o=2.
- R12: Any other opcode, or opcode 000000 with an unlisted function, sets rf_we_o=1, wa_sel_o=3 (register 27), wd_sel_o=2 and pc_sel_o=5 (trap vector). All other fields are idle.
- R13: With rst_i=0 and irq_i=1, the outputs are those of R12 except pc_sel_o=6 (interrupt vector), for every opcode. The store strobe and the less bit stay 0.
- R14: ALU flags have no effect on any output except pc_sel_o for the two branches and less_o for the four set-less-than forms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_i | input | 1 | Reset request, highest priority |
| irq_i | input | 1 | Interrupt request |
| opcode_i | input | 6 | Instruction bits 31..26 |
| funct_i | input | 6 | Instruction bits 5..0 |
| zero_i | input | 1 | ALU result is zero |
| neg_i | input | 1 | ALU result sign bit |
| ovf_i | input | 1 | ALU signed overflow |
| carry_i | input | 1 | ALU carry out of A + ~B + 1 |
| rf_we_o | output | 1 | Register-file write enable |
| a_sel_o | output | 2 | ALU A source: 0 rs, 1 shamt, 2 constant 16 |
| b_sel_o | output | 1 | ALU B source: 0 rt, 1 immediate |
| sext_o | output | 1 | Immediate extension: 1 sign, 0 zero |
| wa_sel_o | output | 2 | Write address: 0 rd, 1 rt, 2 r31, 3 r27 |
| wd_sel_o | output | 2 | Write data: 0 ALU, 1 memory, 2 PC+4, 3 less bit |
| mem_we_o | output | 1 | Data-memory write strobe |
| alu_fn_o | output | 5 | ALU operation code |
| pc_sel_o | output | 3 | Next PC: 0 PC+4, 1 branch, 2 jump, 3 register, 4 reset, 5 trap, 6 interrupt |
| less_o | output | 1 | Less-than result for set-less-than write-back |

## Verification
The block holds no state, so a wrong decode shows at the ports in the same cycle the instruction is presented. The main symptoms are a wrong field in the control vector, a store strobe that survives an interrupt, or a branch that follows the wrong flag. The control vector is compared in full for every supported instruction, for illegal codes and under reset and interrupt. Any field that drifts from its idle value is therefore caught, even where the datapath would ignore it. Flag inputs are driven to values that would flip the result if the decoder watched the wrong flag or the wrong polarity.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int ALU_W = 5;

    // opcode values
    localparam logic [OP_W-1:0] OP_SPECIAL = 6'b000000;
    localparam logic [OP_W-1:0] OP_J       = 6'b000010;
    localparam logic [OP_W-1:0] OP_JAL     = 6'b000011;
    localparam logic [OP_W-1:0] OP_BEQ     = 6'b000100;
    localparam logic [OP_W-1:0] OP_BNE     = 6'b000101;
    localparam logic [OP_W-1:0] OP_ADDI    = 6'b001000;
    localparam logic [OP_W-1:0] OP_ADDIU   = 6'b001001;
    localparam logic [OP_W-1:0] OP_SLTI    = 6'b001010;
    localparam logic [OP_W-1:0] OP_SLTIU   = 6'b001011;
    localparam logic [OP_W-1:0] OP_ANDI    = 6'b001100;
    localparam logic [OP_W-1:0] OP_ORI     = 6'b001101;
    localparam logic [OP_W-1:0] OP_XORI    = 6'b001110;
    localparam logic [OP_W-1:0] OP_LUI     = 6'b001111;
    localparam logic [OP_W-1:0] OP_LW      = 6'b100011;
    localparam logic [OP_W-1:0] OP_SW      = 6'b101011;

    // function values under OP_SPECIAL
    localparam logic [FN_W-1:0] FN_SLL  = 6'b000000;
    localparam logic [FN_W-1:0] FN_SRL  = 6'b000010;
    localparam logic [FN_W-1:0] FN_SRA  = 6'b000011;
    localparam logic [FN_W-1:0] FN_SLLV = 6'b000100;
    localparam logic [FN_W-1:0] FN_SRLV = 6'b000110;
    localparam logic [FN_W-1:0] FN_SRAV = 6'b000111;
    localparam logic [FN_W-1:0] FN_JR   = 6'b001000;
    localparam logic [FN_W-1:0] FN_JALR = 6'b001001;
    localparam logic [FN_W-1:0] FN_ADD  = 6'b100000;
    localparam logic [FN_W-1:0] FN_ADDU = 6'b100001;
    localparam logic [FN_W-1:0] FN_SUB  = 6'b100010;
    localparam logic [FN_W-1:0] FN_SUBU = 6'b100011;
    localparam logic [FN_W-1:0] FN_AND  = 6'b100100;
    localparam logic [FN_W-1:0] FN_OR   = 6'b100101;
    localparam logic [FN_W-1:0] FN_XOR  = 6'b100110;
    localparam logic [FN_W-1:0] FN_NOR  = 6'b100111;
    localparam logic [FN_W-1:0] FN_SLT  = 6'b101010;
    localparam logic [FN_W-1:0] FN_SLTU = 6'b101011;

    typedef enum logic [2:0] {
        PC_SEQ    = 3'd0,
        PC_BRANCH = 3'd1,
        PC_JUMP   = 3'd2,
        PC_REG    = 3'd3,
        PC_RESET  = 3'd4,
        PC_TRAP   = 3'd5,
        PC_IRQ    = 3'd6
    } pc_sel_e;

    typedef enum logic [1:0] {
        A_RS      = 2'd0,
        A_SHAMT   = 2'd1,
        A_SIXTEEN = 2'd2
    } a_sel_e;

    typedef enum logic {
        B_REG = 1'b0,
        B_IMM = 1'b1
    } b_sel_e;

    typedef enum logic [1:0] {
        WA_RD  = 2'd0,
        WA_RT  = 2'd1,
        WA_R31 = 2'd2,
        WA_R27 = 2'd3
    } wa_sel_e;

    typedef enum logic [1:0] {
        WD_ALU  = 2'd0,
        WD_MEM  = 2'd1,
        WD_LINK = 2'd2,
        WD_LESS = 2'd3
    } wd_sel_e;

    typedef enum logic [ALU_W-1:0] {
        ALU_ADD = 5'b00000,
        ALU_SUB = 5'b00001,
        ALU_AND = 5'b01000,
        ALU_OR  = 5'b01001,
        ALU_XOR = 5'b01010,
        ALU_NOR = 5'b01011,
        ALU_SLL = 5'b10000,
        ALU_SRL = 5'b10001,
        ALU_SRA = 5'b10011
    } alu_fn_e;

    typedef enum logic [1:0] {
        CMP_NONE     = 2'd0,
        CMP_SIGNED   = 2'd1,
        CMP_UNSIGNED = 2'd2
    } cmp_e;

    typedef enum logic [1:0] {
        BR_NONE = 2'd0,
        BR_EQ   = 2'd1,
        BR_NE   = 2'd2
    } br_e;

    typedef enum logic [4:0] {
        K_ILLEGAL, K_RALU, K_SHIFT_C, K_SHIFT_V, K_SLT, K_SLTU,
        K_JR, K_JALR, K_IALU_S, K_IALU_Z, K_LUI, K_SLTI, K_SLTIU,
        K_LW, K_SW, K_BEQ, K_BNE, K_J, K_JAL
    } kind_e;

    typedef struct packed {
        kind_e   kind;
        alu_fn_e alu;
    } dec_t;

    typedef struct packed {
        logic    rf_we;
        a_sel_e  a_sel;
        b_sel_e  b_sel;
        logic    sext;
        wa_sel_e wa_sel;
        wd_sel_e wd_sel;
        logic    mem_we;
        alu_fn_e alu_fn;
        pc_sel_e pc_sel;
        cmp_e    cmp;
        br_e     br;
    } ctrl_t;

    typedef struct packed {
        logic    rf_we;
        a_sel_e  a_sel;
        b_sel_e  b_sel;
        logic    sext;
        wa_sel_e wa_sel;
        wd_sel_e wd_sel;
        logic    mem_we;
        alu_fn_e alu_fn;
        pc_sel_e pc_sel;
        logic    less;
    } out_t;

    localparam ctrl_t CTRL_IDLE = '{
        rf_we: 1'b0, a_sel: A_RS, b_sel: B_REG, sext: 1'b1,
        wa_sel: WA_RD, wd_sel: WD_ALU, mem_we: 1'b0, alu_fn: ALU_ADD,
        pc_sel: PC_SEQ, cmp: CMP_NONE, br: BR_NONE
    };

    localparam out_t OUT_IDLE = '{
        rf_we: 1'b0, a_sel: A_RS, b_sel: B_REG, sext: 1'b1,
        wa_sel: WA_RD, wd_sel: WD_ALU, mem_we: 1'b0, alu_fn: ALU_ADD,
        pc_sel: PC_SEQ, less: 1'b0
    };

endpackage

// File: rtl/ctl_instr_dec.sv
// Classifies the opcode/function pair into an instruction kind and
// the ALU operation it needs. Unsupported codes map to K_ILLEGAL.
module ctl_instr_dec
    import ctl_pkg::*;
(
    input  logic [OP_W-1:0] opcode_i,
    input  logic [FN_W-1:0] funct_i,
    output dec_t            dec_o
);

    dec_t dec_d;

    always_comb begin
        dec_d = '{kind: K_ILLEGAL, alu: ALU_ADD};
        case (opcode_i)
            OP_SPECIAL: begin
                case (funct_i)
                    FN_SLL:           dec_d = '{kind: K_SHIFT_C, alu: ALU_SLL};
                    FN_SRL:           dec_d = '{kind: K_SHIFT_C, alu: ALU_SRL};
                    FN_SRA:           dec_d = '{kind: K_SHIFT_C, alu: ALU_SRA};
                    FN_SLLV:          dec_d = '{kind: K_SHIFT_V, alu: ALU_SLL};
                    FN_SRLV:          dec_d = '{kind: K_SHIFT_V, alu: ALU_SRL};
                    FN_SRAV:          dec_d = '{kind: K_SHIFT_V, alu: ALU_SRA};
                    FN_JR:            dec_d = '{kind: K_JR,      alu: ALU_ADD};
                    FN_JALR:          dec_d = '{kind: K_JALR,    alu: ALU_ADD};
                    FN_ADD, FN_ADDU:  dec_d = '{kind: K_RALU,    alu: ALU_ADD};
                    FN_SUB, FN_SUBU:  dec_d = '{kind: K_RALU,    alu: ALU_SUB};
                    FN_AND:           dec_d = '{kind: K_RALU,    alu: ALU_AND};
                    FN_OR:            dec_d = '{kind: K_RALU,    alu: ALU_OR};
                    FN_XOR:           dec_d = '{kind: K_RALU,    alu: ALU_XOR};
                    FN_NOR:           dec_d = '{kind: K_RALU,    alu: ALU_NOR};
                    FN_SLT:           dec_d = '{kind: K_SLT,     alu: ALU_SUB};
                    FN_SLTU:          dec_d = '{kind: K_SLTU,    alu: ALU_SUB};
                    default:          dec_d = '{kind: K_ILLEGAL, alu: ALU_ADD};
                endcase
            end
            OP_ADDI, OP_ADDIU: dec_d = '{kind: K_IALU_S, alu: ALU_ADD};
            OP_ANDI:           dec_d = '{kind: K_IALU_Z, alu: ALU_AND};
            OP_ORI:            dec_d = '{kind: K_IALU_Z, alu: ALU_OR};
            OP_XORI:           dec_d = '{kind: K_IALU_Z, alu: ALU_XOR};
            OP_LUI:            dec_d = '{kind: K_LUI,    alu: ALU_SLL};
            OP_SLTI:           dec_d = '{kind: K_SLTI,   alu: ALU_SUB};
            OP_SLTIU:          dec_d = '{kind: K_SLTIU,  alu: ALU_SUB};
            OP_LW:             dec_d = '{kind: K_LW,     alu: ALU_ADD};
            OP_SW:             dec_d = '{kind: K_SW,     alu: ALU_ADD};
            OP_BEQ:            dec_d = '{kind: K_BEQ,    alu: ALU_SUB};
            OP_BNE:            dec_d = '{kind: K_BNE,    alu: ALU_SUB};
            OP_J:              dec_d = '{kind: K_J,      alu: ALU_ADD};
            OP_JAL:            dec_d = '{kind: K_JAL,    alu: ALU_ADD};
            default:           dec_d = '{kind: K_ILLEGAL, alu: ALU_ADD};
        endcase
    end

    assign dec_o = dec_d;

endmodule

// File: rtl/ctl_ctrl_table.sv
// Maps an instruction kind to its base control vector. Branch and
// compare resolution against the flags happens downstream.
module ctl_ctrl_table
    import ctl_pkg::*;
(
    input  dec_t  dec_i,
    output ctrl_t ctrl_o
);

    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d        = CTRL_IDLE;
        ctrl_d.alu_fn = dec_i.alu;
        case (dec_i.kind)
            K_RALU: begin
                ctrl_d.rf_we = 1'b1;
            end
            K_SHIFT_C: begin
                ctrl_d.rf_we = 1'b1;
                ctrl_d.a_sel = A_SHAMT;
            end
            K_SHIFT_V: begin
                ctrl_d.rf_we = 1'b1;
            end
            K_SLT, K_SLTU: begin
                ctrl_d.rf_we  = 1'b1;
                ctrl_d.wd_sel = WD_LESS;
                ctrl_d.cmp    = (dec_i.kind == K_SLT) ? CMP_SIGNED : CMP_UNSIGNED;
            end
            K_JR: begin
                ctrl_d.pc_sel = PC_REG;
            end
            K_JALR: begin
                ctrl_d.rf_we  = 1'b1;
                ctrl_d.wd_sel = WD_LINK;
                ctrl_d.pc_sel = PC_REG;
            end
            K_IALU_S, K_IALU_Z: begin
                ctrl_d.rf_we  = 1'b1;
                ctrl_d.b_sel  = B_IMM;
                ctrl_d.wa_sel = WA_RT;
                ctrl_d.sext   = (dec_i.kind == K_IALU_S);
            end
            K_LUI: begin
                ctrl_d.rf_we  = 1'b1;
                ctrl_d.a_sel  = A_SIXTEEN;
                ctrl_d.b_sel  = B_IMM;
                ctrl_d.sext   = 1'b0;
                ctrl_d.wa_sel = WA_RT;
            end
            K_SLTI, K_SLTIU: begin
                ctrl_d.rf_we  = 1'b1;
                ctrl_d.b_sel  = B_IMM;
                ctrl_d.wa_sel = WA_RT;
                ctrl_d.wd_sel = WD_LESS;
                ctrl_d.cmp    = (dec_i.kind == K_SLTI) ? CMP_SIGNED : CMP_UNSIGNED;
            end
            K_LW: begin
                ctrl_d.rf_we  = 1'b1;
                ctrl_d.b_sel  = B_IMM;
                ctrl_d.wa_sel = WA_RT;
                ctrl_d.wd_sel = WD_MEM;
            end
            K_SW: begin
                ctrl_d.b_sel  = B_IMM;
                ctrl_d.mem_we = 1'b1;
            end
            K_BEQ, K_BNE: begin
                ctrl_d.pc_sel = PC_BRANCH;
                ctrl_d.br     = (dec_i.kind == K_BEQ) ? BR_EQ : BR_NE;
            end
            K_J: begin
                ctrl_d.pc_sel = PC_JUMP;
            end
            K_JAL: begin
                ctrl_d.rf_we  = 1'b1;
                ctrl_d.wa_sel = WA_R31;
                ctrl_d.wd_sel = WD_LINK;
                ctrl_d.pc_sel = PC_JUMP;
            end
            default: begin
                ctrl_d.rf_we  = 1'b1;
                ctrl_d.wa_sel = WA_R27;
                ctrl_d.wd_sel = WD_LINK;
                ctrl_d.pc_sel = PC_TRAP;
            end
        endcase
    end

    assign ctrl_o = ctrl_d;

endmodule

// File: rtl/ctl_flow_sel.sv
// Resolves branch direction and the less-than bit from the ALU flags,
// then applies reset and interrupt overrides in priority order.
module ctl_flow_sel
    import ctl_pkg::*;
(
    input  ctrl_t ctrl_i,
    input  logic  rst_i,
    input  logic  irq_i,
    input  logic  zero_i,
    input  logic  neg_i,
    input  logic  ovf_i,
    input  logic  carry_i,
    output out_t  out_o
);

    out_t out_d;
    logic taken_d;
    logic less_d;

    always_comb begin
        taken_d = ((ctrl_i.br == BR_EQ) &&  zero_i) ||
                  ((ctrl_i.br == BR_NE) && !zero_i);

        case (ctrl_i.cmp)
            CMP_SIGNED:   less_d = neg_i ^ ovf_i;
            CMP_UNSIGNED: less_d = ~carry_i;
            default:      less_d = 1'b0;
        endcase

        out_d.rf_we  = ctrl_i.rf_we;
        out_d.a_sel  = ctrl_i.a_sel;
        out_d.b_sel  = ctrl_i.b_sel;
        out_d.sext   = ctrl_i.sext;
        out_d.wa_sel = ctrl_i.wa_sel;
        out_d.wd_sel = ctrl_i.wd_sel;
        out_d.mem_we = ctrl_i.mem_we;
        out_d.alu_fn = ctrl_i.alu_fn;
        out_d.pc_sel = ctrl_i.pc_sel;
        out_d.less   = less_d;
        if ((ctrl_i.br != BR_NONE) && !taken_d) begin
            out_d.pc_sel = PC_SEQ;
        end

        if (rst_i) begin
            out_d        = OUT_IDLE;
            out_d.pc_sel = PC_RESET;
        end else if (irq_i) begin
            out_d        = OUT_IDLE;
            out_d.rf_we  = 1'b1;
            out_d.wa_sel = WA_R27;
            out_d.wd_sel = WD_LINK;
            out_d.pc_sel = PC_IRQ;
        end
    end

    assign out_o = out_d;

endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
    import ctl_pkg::*;
(
    input  logic             rst_i,
    input  logic             irq_i,
    input  logic [OP_W-1:0]  opcode_i,
    input  logic [FN_W-1:0]  funct_i,
    input  logic             zero_i,
    input  logic             neg_i,
    input  logic             ovf_i,
    input  logic             carry_i,
    output logic             rf_we_o,
    output logic [1:0]       a_sel_o,
    output logic             b_sel_o,
    output logic             sext_o,
    output logic [1:0]       wa_sel_o,
    output logic [1:0]       wd_sel_o,
    output logic             mem_we_o,
    output logic [ALU_W-1:0] alu_fn_o,
    output logic [2:0]       pc_sel_o,
    output logic             less_o
);

    dec_t  dec_d;
    ctrl_t ctrl_d;
    out_t  out_d;

    ctl_instr_dec u_dec (
        .opcode_i (opcode_i),
        .funct_i  (funct_i),
        .dec_o    (dec_d)
    );

    ctl_ctrl_table u_table (
        .dec_i  (dec_d),
        .ctrl_o (ctrl_d)
    );

    ctl_flow_sel u_flow (
        .ctrl_i  (ctrl_d),
        .rst_i   (rst_i),
        .irq_i   (irq_i),
        .zero_i  (zero_i),
        .neg_i   (neg_i),
        .ovf_i   (ovf_i),
        .carry_i (carry_i),
        .out_o   (out_d)
    );

    assign rf_we_o  = out_d.rf_we;
    assign a_sel_o  = out_d.a_sel;
    assign b_sel_o  = out_d.b_sel;
    assign sext_o   = out_d.sext;
    assign wa_sel_o = out_d.wa_sel;
    assign wd_sel_o = out_d.wd_sel;
    assign mem_we_o = out_d.mem_we;
    assign alu_fn_o = out_d.alu_fn;
    assign pc_sel_o = out_d.pc_sel;
    assign less_o   = out_d.less;

endmodule

// File: rtl/ctl_decoder_chk.sv
module ctl_decoder_chk (
    input logic       rst_i,
    input logic       irq_i,
    input logic [5:0] opcode_i,
    input logic [5:0] funct_i,
    input logic       zero_i,
    input logic       neg_i,
    input logic       ovf_i,
    input logic       carry_i,
    input logic       rf_we_o,
    input logic [1:0] a_sel_o,
    input logic       b_sel_o,
    input logic       sext_o,
    input logic [1:0] wa_sel_o,
    input logic [1:0] wd_sel_o,
    input logic       mem_we_o,
    input logic [4:0] alu_fn_o,
    input logic [2:0] pc_sel_o,
    input logic       less_o
);

    always_comb begin
        if (rst_i) begin
            assert_reset_quiet_R1: assert (pc_sel_o == 3'd4 && !rf_we_o && !mem_we_o)
                else $error("reset did not quiet the control vector");
        end
        if (!rst_i && irq_i) begin
            assert_irq_vector_R13: assert (pc_sel_o == 3'd6 && rf_we_o && wa_sel_o == 2'd3 &&
                                           wd_sel_o == 2'd2 && !mem_we_o && !less_o)
                else $error("interrupt override incomplete");
        end
        if (mem_we_o) begin
            assert_store_only_R8: assert (opcode_i == 6'b101011 && !rst_i && !irq_i && !rf_we_o)
                else $error("memory write outside a store");
        end
        if (pc_sel_o == 3'd1) begin
            assert_branch_flag_R9: assert ((opcode_i == 6'b000100 && zero_i) ||
                                           (opcode_i == 6'b000101 && !zero_i))
                else $error("branch taken against the zero flag");
        end
        if (less_o) begin
            assert_less_path_R7: assert (wd_sel_o == 2'd3 && rf_we_o)
                else $error("less bit raised without less write-back");
        end
        if (!rst_i && !irq_i && opcode_i == 6'b000000 && funct_i == 6'b101010) begin
            assert_slt_signed_R7: assert (less_o == (neg_i ^ ovf_i))
                else $error("signed less bit wrong");
        end
        if (!rst_i && !irq_i && opcode_i == 6'b001011) begin
            assert_sltiu_unsigned_R7: assert (less_o == !carry_i)
                else $error("unsigned less bit wrong");
        end
        if (a_sel_o == 2'd2) begin
            assert_upper_imm_R6: assert (b_sel_o && !sext_o && alu_fn_o == 5'b10000)
                else $error("constant-16 path without upper-immediate controls");
        end
        if (wd_sel_o == 2'd2) begin
            assert_link_writes_R10: assert (rf_we_o)
                else $error("link data selected without a register write");
        end
    end

endmodule

bind ctl_decoder ctl_decoder_chk u_chk (
    .rst_i    (rst_i),
    .irq_i    (irq_i),
    .opcode_i (opcode_i),
    .funct_i  (funct_i),
    .zero_i   (zero_i),
    .neg_i    (neg_i),
    .ovf_i    (ovf_i),
    .carry_i  (carry_i),
    .rf_we_o  (rf_we_o),
    .a_sel_o  (a_sel_o),
    .b_sel_o  (b_sel_o),
    .sext_o   (sext_o),
    .wa_sel_o (wa_sel_o),
    .wd_sel_o (wd_sel_o),
    .mem_we_o (mem_we_o),
    .alu_fn_o (alu_fn_o),
    .pc_sel_o (pc_sel_o),
    .less_o   (less_o)
);

// File: tb/ctl_decoder_bench.sv
module ctl_decoder_bench;

    localparam int PERIOD = 8;
    localparam int NV     = 51;

    logic clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    logic       rst_i, irq_i, zero_i, neg_i, ovf_i, carry_i;
    logic [5:0] opcode_i, funct_i;
    logic       rf_we_o, b_sel_o, sext_o, mem_we_o, less_o;
    logic [1:0] a_sel_o, wa_sel_o, wd_sel_o;
    logic [4:0] alu_fn_o;
    logic [2:0] pc_sel_o;

    ctl_decoder u_ctl_decoder (
        .rst_i (rst_i), .irq_i (irq_i), .opcode_i (opcode_i), .funct_i (funct_i),
        .zero_i (zero_i), .neg_i (neg_i), .ovf_i (ovf_i), .carry_i (carry_i),
        .rf_we_o (rf_we_o), .a_sel_o (a_sel_o), .b_sel_o (b_sel_o), .sext_o (sext_o),
        .wa_sel_o (wa_sel_o), .wd_sel_o (wd_sel_o), .mem_we_o (mem_we_o),
        .alu_fn_o (alu_fn_o), .pc_sel_o (pc_sel_o), .less_o (less_o)
    );

    // expected vector: we_asel_bsel_sext_wasel_wdsel_memwe_alu_pc_less
    wire [18:0] act_vec = {rf_we_o, a_sel_o, b_sel_o, sext_o, wa_sel_o, wd_sel_o,
                           mem_we_o, alu_fn_o, pc_sel_o, less_o};

    typedef struct packed {
        logic [3:0]  req;
        logic        rst;
        logic        irq;
        logic [5:0]  op;
        logic [5:0]  fn;
        logic [3:0]  flg;   // zero, neg, ovf, carry
        logic [18:0] exp;
    } vec_t;

    localparam logic [40:0] VECS [NV] = '{
        // R1 reset dominates
        {4'd1, 2'b10, 6'b000000, 6'b100000, 4'b0000, 19'b0_00_0_1_00_00_0_00000_100_0},
        {4'd1, 2'b11, 6'b101011, 6'b000000, 4'b1111, 19'b0_00_0_1_00_00_0_00000_100_0},
        {4'd1, 2'b10, 6'b111111, 6'b111111, 4'b0100, 19'b0_00_0_1_00_00_0_00000_100_0},
        // R3 register ALU
        {4'd3, 2'b00, 6'b000000, 6'b100000, 4'b0000, 19'b1_00_0_1_00_00_0_00000_000_0},
        {4'd3, 2'b00, 6'b000000, 6'b100001, 4'b0000, 19'b1_00_0_1_00_00_0_00000_000_0},
        {4'd3, 2'b00, 6'b000000, 6'b100010, 4'b0000, 19'b1_00_0_1_00_00_0_00001_000_0},
        {4'd3, 2'b00, 6'b000000, 6'b100011, 4'b0000, 19'b1_00_0_1_00_00_0_00001_000_0},
        {4'd3, 2'b00, 6'b000000, 6'b100100, 4'b0000, 19'b1_00_0_1_00_00_0_01000_000_0},
        {4'd3, 2'b00, 6'b000000, 6'b100101, 4'b0000, 19'b1_00_0_1_00_00_0_01001_000_0},
        {4'd3, 2'b00, 6'b000000, 6'b100110, 4'b0000, 19'b1_00_0_1_00_00_0_01010_000_0},
        {4'd3, 2'b00, 6'b000000, 6'b100111, 4'b0000, 19'b1_00_0_1_00_00_0_01011_000_0},
        // R4 shifts
        {4'd4, 2'b00, 6'b000000, 6'b000000, 4'b0000, 19'b1_01_0_1_00_00_0_10000_000_0},
        {4'd4, 2'b00, 6'b000000, 6'b000010, 4'b0000, 19'b1_01_0_1_00_00_0_10001_000_0},
        {4'd4, 2'b00, 6'b000000, 6'b000011, 4'b0000, 19'b1_01_0_1_00_00_0_10011_000_0},
        {4'd4, 2'b00, 6'b000000, 6'b000100, 4'b0000, 19'b1_00_0_1_00_00_0_10000_000_0},
        {4'd4, 2'b00, 6'b000000, 6'b000110, 4'b0000, 19'b1_00_0_1_00_00_0_10001_000_0},
        {4'd4, 2'b00, 6'b000000, 6'b000111, 4'b0000, 19'b1_00_0_1_00_00_0_10011_000_0},
        // R5 immediate ALU
        {4'd5, 2'b00, 6'b001000, 6'b000000, 4'b0000, 19'b1_00_1_1_01_00_0_00000_000_0},
        {4'd5, 2'b00, 6'b001001, 6'b101010, 4'b0000, 19'b1_00_1_1_01_00_0_00000_000_0},
        {4'd5, 2'b00, 6'b001100, 6'b000000, 4'b0000, 19'b1_00_1_0_01_00_0_01000_000_0},
        {4'd5, 2'b00, 6'b001101, 6'b000000, 4'b0000, 19'b1_00_1_0_01_00_0_01001_000_0},
        {4'd5, 2'b00, 6'b001110, 6'b000000, 4'b0000, 19'b1_00_1_0_01_00_0_01010_000_0},
        // R6 load upper
        {4'd6, 2'b00, 6'b001111, 6'b000000, 4'b0000, 19'b1_10_1_0_01_00_0_10000_000_0},
        // R7 set-less-than
        {4'd7, 2'b00, 6'b000000, 6'b101010, 4'b0100, 19'b1_00_0_1_00_11_0_00001_000_1},
        {4'd7, 2'b00, 6'b000000, 6'b101010, 4'b0110, 19'b1_00_0_1_00_11_0_00001_000_0},
        {4'd7, 2'b00, 6'b000000, 6'b101011, 4'b0000, 19'b1_00_0_1_00_11_0_00001_000_1},
        {4'd7, 2'b00, 6'b000000, 6'b101011, 4'b0001, 19'b1_00_0_1_00_11_0_00001_000_0},
        {4'd7, 2'b00, 6'b001010, 6'b000000, 4'b0010, 19'b1_00_1_1_01_11_0_00001_000_1},
        {4'd7, 2'b00, 6'b001011, 6'b000000, 4'b0001, 19'b1_00_1_1_01_11_0_00001_000_0},
        {4'd7, 2'b00, 6'b001011, 6'b000000, 4'b0110, 19'b1_00_1_1_01_11_0_00001_000_1},
        // R8 load and store
        {4'd8, 2'b00, 6'b100011, 6'b000000, 4'b0000, 19'b1_00_1_1_01_01_0_00000_000_0},
        {4'd8, 2'b00, 6'b101011, 6'b000000, 4'b0000, 19'b0_00_1_1_00_00_1_00000_000_0},
        // R9 branches
        {4'd9, 2'b00, 6'b000100, 6'b000000, 4'b1000, 19'b0_00_0_1_00_00_0_00001_001_0},
        {4'd9, 2'b00, 6'b000100, 6'b000000, 4'b0111, 19'b0_00_0_1_00_00_0_00001_000_0},
        {4'd9, 2'b00, 6'b000101, 6'b000000, 4'b0000, 19'b0_00_0_1_00_00_0_00001_001_0},
        {4'd9, 2'b00, 6'b000101, 6'b000000, 4'b1000, 19'b0_00_0_1_00_00_0_00001_000_0},
        // R10 jumps
        {4'd10, 2'b00, 6'b000010, 6'b000000, 4'b0000, 19'b0_00_0_1_00_00_0_00000_010_0},
        {4'd10, 2'b00, 6'b000011, 6'b000000, 4'b0000, 19'b1_00_0_1_10_10_0_00000_010_0},
        // R11 register jumps
        {4'd11, 2'b00, 6'b000000, 6'b001000, 4'b0000, 19'b0_00_0_1_00_00_0_00000_011_0},
        {4'd11, 2'b00, 6'b000000, 6'b001001, 4'b0000, 19'b1_00_0_1_00_10_0_00000_011_0},
        // R12 illegal codes
        {4'd12, 2'b00, 6'b111111, 6'b000000, 4'b0000, 19'b1_00_0_1_11_10_0_00000_101_0},
        {4'd12, 2'b00, 6'b000000, 6'b000001, 4'b0000, 19'b1_00_0_1_11_10_0_00000_101_0},
        {4'd12, 2'b00, 6'b100000, 6'b000000, 4'b0000, 19'b1_00_0_1_11_10_0_00000_101_0},
        {4'd12, 2'b00, 6'b000001, 6'b101010, 4'b0100, 19'b1_00_0_1_11_10_0_00000_101_0},
        // R13 interrupt override
        {4'd13, 2'b01, 6'b101011, 6'b000000, 4'b0000, 19'b1_00_0_1_11_10_0_00000_110_0},
        {4'd13, 2'b01, 6'b000100, 6'b000000, 4'b1000, 19'b1_00_0_1_11_10_0_00000_110_0},
        {4'd13, 2'b01, 6'b111111, 6'b000000, 4'b0000, 19'b1_00_0_1_11_10_0_00000_110_0},
        {4'd13, 2'b01, 6'b000000, 6'b101010, 4'b0100, 19'b1_00_0_1_11_10_0_00000_110_0},
        // R14 flags ignored outside branches and compares
        {4'd14, 2'b00, 6'b000000, 6'b100000, 4'b1111, 19'b1_00_0_1_00_00_0_00000_000_0},
        {4'd14, 2'b00, 6'b000010, 6'b000000, 4'b1111, 19'b0_00_0_1_00_00_0_00000_010_0},
        {4'd14, 2'b00, 6'b100011, 6'b000000, 4'b0110, 19'b1_00_1_1_01_01_0_00000_000_0}
    };

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    task automatic check_vec(input string tag, input logic [18:0] exp);
        n_checks++;
        if (act_vec !== exp) begin
            n_fail++;
            $display("FAIL %s act=%b exp=%b", tag, act_vec, exp);
        end
    endtask

    task automatic drive(input logic r, input logic q, input logic [5:0] op,
                         input logic [5:0] fn, input logic [3:0] flg);
        @(posedge clk);
        rst_i    = r;
        irq_i    = q;
        opcode_i = op;
        funct_i  = fn;
        {zero_i, neg_i, ovf_i, carry_i} = flg;
        @(negedge clk);
    endtask

    initial begin
        rst_i = 1'b1; irq_i = 1'b0; opcode_i = '0; funct_i = '0;
        {zero_i, neg_i, ovf_i, carry_i} = 4'b0000;
        @(negedge clk);
        // R1 reset state at start
        check_vec("R1 initial reset", 19'b0_00_0_1_00_00_0_00000_100_0);

        // R2 idle fields are covered in every table row
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(VECS[i]);
            drive(v.rst, v.irq, v.op, v.fn, v.flg);
            check_vec($sformatf("R%0d row %0d", v.req, i), v.exp);
        end

        // R13 every opcode yields the interrupt vector
        for (int op = 0; op < 64; op++) begin
            drive(1'b0, 1'b1, op[5:0], 6'b101010, 4'b0100);
            check_vec($sformatf("R13 irq opcode %0d", op),
                      19'b1_00_0_1_11_10_0_00000_110_0);
        end

        // R1 reset beats interrupt for every opcode
        for (int op = 0; op < 64; op++) begin
            drive(1'b1, 1'b1, op[5:0], 6'b000000, 4'b1000);
            check_vec($sformatf("R1 reset opcode %0d", op),
                      19'b0_00_0_1_00_00_0_00000_100_0);
        end

        // R2 release to an idle-shaped instruction
        drive(1'b0, 1'b0, 6'b000010, 6'b000000, 4'b0000);
        check_vec("R2 jump idle fields", 19'b0_00_0_1_00_00_0_00000_010_0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule